// File: doc/BRIEF.md
# Serial Upload Receiver with 24-bit Word Packing

This block receives an asynchronous serial byte stream from a host (idle-high line, one low start bit, eight data bits least significant first, no parity, one high stop bit) and turns it into writes for a 24-bit-wide memory. The line is resynchronised by two flops and oversampled sixteen times per bit. The oversampling tick comes from a system-clock divider, and a run-time select input chooses between two divider values. With the default parameters at a 125 MHz clock, these give 9600 and 19200 baud.

Every byte that passes both the start-bit and stop-bit checks is collected. Three such bytes form one word, which is written with a one-cycle strobe to an address that counts up from zero. An upload has no explicit end marker. It ends when no byte has been accepted for a long, parameterised span of clocks (ten seconds by default). At that point any partial word is dropped, the address returns to zero and a one-cycle done pulse is raised. The next accepted byte starts a fresh upload.

Top module: `serial_word_loader`

## Requirements
- R1: `rate_sel` = 0 makes the oversampling tick occur every `DIV_SLOW` clocks, and `rate_sel` = 1 makes it occur every `DIV_FAST` clocks. One bit lasts 16 ticks, and both divisors are at least 2.
- R2: A falling line starts a frame only if the line is still low at the eighth tick after detection (mid start bit). A shorter low pulse is dropped without effect.
- R3: The eight data bits are sampled at mid-bit, 16 ticks apart, and the first bit received is bit 0 of the byte. No parity bit is expected.
- R4: A byte is accepted only when the stop-bit sample is high. A byte with a low stop sample is discarded, leaves the word assembly untouched, and the receiver waits for the line to return high.
- R5: Three accepted bytes make one word: the first goes to `wr_data[7:0]`, the second to `[15:8]` and the third to `[23:16]`. `wr_en` pulses for exactly one cycle, one clock after the third byte is accepted, and this falls before the end of that byte's stop bit.
- R6: The first write of an upload uses `wr_addr` = 0, and `wr_addr` increases by one after each write.
- R7: The inactivity count restarts on each accepted byte. After `TIMEOUT_CLKS` clocks without an accepted byte during an upload, `done` pulses for one cycle, the partial word is dropped and `wr_addr` returns to 0.
- R8: While reset is held, `wr_en` = 0, `done` = 0 and `wr_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 1 | Rate select: 0 uses DIV_SLOW, 1 uses DIV_FAST |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | ADDR_W | Word address of the current write |
| wr_data | output | 24 | Packed word |
| done | output | 1 | One-cycle pulse when an upload times out |

## Verification
A byte is accepted at the mid-stop sample. That point is nine and a half bit times after the start edge, plus two synchroniser clocks and up to one tick of detection delay. The write strobe follows one clock later, so the bench requires the expected word to have left its queue by the time the driver finishes that stop bit. The done pulse is due about `TIMEOUT_CLKS` clocks after the mid-stop point of the last accepted byte. The bench therefore checks that no done has occurred one bit time before that instant and that exactly one has occurred a bit time plus a small margin after it. All comparisons are made on the falling clock edge, away from the edge where the design updates.

// File: rtl/swl_pkg.sv
package swl_pkg;

  localparam int OVS_TICKS = 16;
  localparam int MID_TICK  = OVS_TICKS / 2;
  localparam int WORD_W    = 24;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_t;

  // Pick the oversampling divisor for the selected rate.
  function automatic int pick_div(input logic sel, input int slow, input int fast);
    return sel ? fast : slow;
  endfunction

  // Insert a newly sampled bit at the top; after eight bits the first is at bit 0.
  function automatic logic [7:0] lsb_first_shift(input logic [7:0] sr, input logic b);
    return {b, sr[7:1]};
  endfunction

  // Join three bytes, oldest in the low lane.
  function automatic logic [WORD_W-1:0] join_word(input logic [7:0] third,
                                                  input logic [7:0] second,
                                                  input logic [7:0] first);
    return {third, second, first};
  endfunction

endpackage

// File: rtl/swl_tick_gen.sv
module swl_tick_gen #(
  parameter int DIV_SLOW = 814,
  parameter int DIV_FAST = 407
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_sel,
  output logic tick
);
  import swl_pkg::*;

  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int DIV_W   = $clog2(DIV_MAX + 1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_now;

  assign div_now = DIV_W'(pick_div(rate_sel, DIV_SLOW, DIV_FAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div_now - DIV_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/swl_sync.sv
module swl_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= 1'b1;
      q    <= 1'b1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/swl_byte_rx.sv
module swl_byte_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  output logic       byte_ok,
  output logic       frame_err,
  output logic       start_drop,
  output logic [7:0] byte_out
);
  import swl_pkg::*;

  rx_state_t  state;
  logic [3:0] tcnt;
  logic [2:0] bidx;
  logic [7:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      tcnt       <= '0;
      bidx       <= '0;
      sr         <= '0;
      byte_out   <= '0;
      byte_ok    <= 1'b0;
      frame_err  <= 1'b0;
      start_drop <= 1'b0;
    end else begin
      byte_ok    <= 1'b0;
      frame_err  <= 1'b0;
      start_drop <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (tick && !line) begin
            state <= RX_START;
            tcnt  <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (tcnt == 4'(MID_TICK - 1)) begin
              tcnt <= '0;
              bidx <= '0;
              if (!line) begin
                state <= RX_DATA;
              end else begin
                state      <= RX_IDLE;
                start_drop <= 1'b1;
              end
            end else begin
              tcnt <= tcnt + 4'd1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (tcnt == 4'(OVS_TICKS - 1)) begin
              tcnt <= '0;
              sr   <= lsb_first_shift(sr, line);
              if (bidx == 3'd7) state <= RX_STOP;
              else              bidx  <= bidx + 3'd1;
            end else begin
              tcnt <= tcnt + 4'd1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (tcnt == 4'(OVS_TICKS - 1)) begin
              tcnt <= '0;
              if (line) begin
                byte_ok  <= 1'b1;
                byte_out <= sr;
                state    <= RX_IDLE;
              end else begin
                frame_err <= 1'b1;
                state     <= RX_WAIT_HIGH;
              end
            end else begin
              tcnt <= tcnt + 4'd1;
            end
          end
        end
        RX_WAIT_HIGH: begin
          if (line) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/swl_packer.sv
module swl_packer #(
  parameter int ADDR_W       = 12,
  parameter int TIMEOUT_CLKS = 1_250_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_ok,
  input  logic [7:0]        byte_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [23:0]       wr_data,
  output logic              done
);
  import swl_pkg::*;

  localparam int TW = $clog2(TIMEOUT_CLKS + 1);

  logic [7:0]    lane0;
  logic [7:0]    lane1;
  logic [1:0]    fill;
  logic          active;
  logic [TW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane0    <= '0;
      lane1    <= '0;
      fill     <= '0;
      active   <= 1'b0;
      idle_cnt <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      if (wr_en) wr_addr <= wr_addr + ADDR_W'(1);
      if (byte_ok) begin
        active   <= 1'b1;
        idle_cnt <= '0;
        case (fill)
          2'd0: begin
            lane0 <= byte_in;
            fill  <= 2'd1;
          end
          2'd1: begin
            lane1 <= byte_in;
            fill  <= 2'd2;
          end
          default: begin
            wr_data <= join_word(byte_in, lane1, lane0);
            wr_en   <= 1'b1;
            fill    <= 2'd0;
          end
        endcase
      end else if (active) begin
        if (idle_cnt == TW'(TIMEOUT_CLKS - 1)) begin
          done     <= 1'b1;
          active   <= 1'b0;
          fill     <= 2'd0;
          idle_cnt <= '0;
          wr_addr  <= '0;
        end else begin
          idle_cnt <= idle_cnt + TW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader #(
  parameter int DIV_SLOW     = 814,
  parameter int DIV_FAST     = 407,
  parameter int ADDR_W       = 12,
  parameter int TIMEOUT_CLKS = 1_250_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_sel,
  input  logic              rx_line,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [23:0]       wr_data,
  output logic              done
);

  // Named internal events, visible to the bound checker.
  logic       tick;
  logic       line_s;
  logic       byte_ok;
  logic       frame_err;
  logic       start_drop;
  logic [7:0] byte_val;

  swl_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_line),
    .q     (line_s)
  );

  swl_tick_gen #(
    .DIV_SLOW (DIV_SLOW),
    .DIV_FAST (DIV_FAST)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .tick     (tick)
  );

  swl_byte_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .line       (line_s),
    .byte_ok    (byte_ok),
    .frame_err  (frame_err),
    .start_drop (start_drop),
    .byte_out   (byte_val)
  );

  swl_packer #(
    .ADDR_W       (ADDR_W),
    .TIMEOUT_CLKS (TIMEOUT_CLKS)
  ) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_ok (byte_ok),
    .byte_in (byte_val),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .done    (done)
  );

endmodule

// File: rtl/swl_checker.sv
module swl_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              byte_ok,
  input logic              frame_err,
  input logic              start_drop,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done
);

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R2, R4: a frame ends in at most one outcome per cycle
  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_ok, frame_err, start_drop}));

  p_err_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !wr_en);

  p_write_after_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(byte_ok));

  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_en && wr_addr == '0));

endmodule

bind serial_word_loader swl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .byte_ok    (byte_ok),
  .frame_err  (frame_err),
  .start_drop (start_drop),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .done       (done)
);

// File: tb/serial_word_loader_test.sv
module serial_word_loader_test;

  localparam int DS = 8;
  localparam int DF = 4;
  localparam int AW = 8;
  localparam int TO = 3000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rate_sel = 1'b0;
  logic          rx_line = 1'b1;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [23:0]   wr_data;
  logic          done;

  int tests = 0;
  int fails = 0;
  int done_cnt = 0;

  logic [AW+23:0] exp_q[$];
  int             nb = 0;
  logic [7:0]     held0, held1;
  logic [AW-1:0]  exp_addr = '0;

  always #4 clk = ~clk;

  serial_word_loader #(
    .DIV_SLOW(DS), .DIV_FAST(DF), .ADDR_W(AW), .TIMEOUT_CLKS(TO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .rx_line(rx_line),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return 16 * (rate_sel ? DF : DS);
  endfunction

  // Scoreboard model of word packing (R5, R6) and timeout reset (R7)
  task automatic model_byte(input logic [7:0] b);
    if (nb == 2) begin
      exp_q.push_back({exp_addr, b, held1, held0});
      exp_addr = exp_addr + 1'b1;
      nb = 0;
    end else begin
      if (nb == 0) held0 = b; else held1 = b;
      nb++;
    end
  endtask

  task automatic drive_frame(input logic [7:0] b, input bit stop_hi);
    int bl;
    bl = bit_clks();
    rx_line = 1'b0;
    repeat (bl) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      repeat (bl) @(negedge clk);
    end
    rx_line = stop_hi;
    repeat (bl) @(negedge clk);
    rx_line = 1'b1;
  endtask

  task automatic send_good(input logic [7:0] b);
    bit third;
    third = (nb == 2);
    model_byte(b);
    drive_frame(b, 1'b1);
    if (third)
      check(exp_q.size() == 0, "R5", "word not written by end of stop bit",
            exp_q.size(), 0);
    repeat (10) @(negedge clk);
  endtask

  task automatic send_bad(input logic [7:0] b);
    drive_frame(b, 1'b0);
    repeat (2 * bit_clks()) @(negedge clk);
  endtask

  task automatic glitch();
    rx_line = 1'b0;
    repeat (3 * (rate_sel ? DF : DS)) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * bit_clks()) @(negedge clk);
  endtask

  task automatic wait_timeout();
    int d0;
    d0 = done_cnt;
    repeat (TO - bit_clks()) @(negedge clk);
    check(done_cnt == d0, "R7", "done before timeout", done_cnt - d0, 0);
    repeat (bit_clks() + 24) @(negedge clk);
    check(done_cnt == d0 + 1, "R7", "done pulses after timeout", done_cnt - d0, 1);
    check(wr_addr == '0, "R7", "address back to zero", wr_addr, 0);
    nb = 0;
    exp_addr = '0;
  endtask

  // Monitor: compares each write against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && done) done_cnt++;
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected write", {wr_addr, wr_data}, 0);
      end else begin
        logic [AW+23:0] e;
        e = exp_q.pop_front();
        check(wr_data == e[23:0], "R5", "write data", wr_data, e[23:0]);
        check(wr_addr == e[AW+23:24], "R6", "write address", wr_addr, e[AW+23:24]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d0;
    repeat (5) @(negedge clk);
    check(wr_en == 1'b0, "R8", "wr_en in reset", wr_en, 0);
    check(done == 1'b0, "R8", "done in reset", done, 0);
    check(wr_addr == '0, "R8", "wr_addr in reset", wr_addr, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R1, R3, R5, R6: slow rate, two words
    send_good(8'hA5); send_good(8'h3C); send_good(8'h0F);
    send_good(8'h81); send_good(8'h7E); send_good(8'hC3);
    wait_timeout();

    // R1, R3: fast rate, bit-order patterns, new upload at address 0
    rate_sel = 1'b1;
    repeat (50) @(negedge clk);
    send_good(8'h01); send_good(8'h80); send_good(8'hFF);

    // R4: bad stop discarded; R2: short start pulse dropped
    send_good(8'h11);
    send_bad(8'hEE);
    glitch();
    send_good(8'h22);
    send_good(8'h33);
    wait_timeout();

    // R7: partial word dropped at timeout, next upload restarts
    send_good(8'h44); send_good(8'h55);
    wait_timeout();
    check(exp_q.size() == 0, "R7", "partial word written", exp_q.size(), 0);
    send_good(8'h66); send_good(8'h77); send_good(8'h99);
    wait_timeout();

    // R7: count restarts on each byte, span longer than timeout
    rate_sel = 1'b0;
    repeat (50) @(negedge clk);
    d0 = done_cnt;
    send_good(8'hDE);
    repeat (1200) @(negedge clk);
    send_good(8'hAD);
    repeat (1200) @(negedge clk);
    send_good(8'hBE);
    check(done_cnt == d0, "R7", "done while bytes keep coming", done_cnt - d0, 0);
    wait_timeout();

    check(exp_q.size() == 0, "R5", "writes still pending", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule